// File: doc/BRIEF.md
# Sensor Capture Window and Write-Enable Gate

This block sits at the front of a camera input path and runs in the pixel clock domain. It takes a raw sample of up to 14 bits each clock, with horizontal and vertical sync. From the sync edges it tracks the current pixel and line position. It compares that position with a programmable rectangle to decide which samples are written to memory. The result is a one-cycle-delayed write strobe with the matching sample. The sample can be passed through at full width or cut to an 8-bit slice with saturation. The low bits of a narrower sensor can be cleared.

One shared input pin has two roles. In write-enable mode it is merged with the in-window flag by an AND or an OR rule. In field mode it carries a field identifier. The block can either latch that identifier from the sensor, or generate it and drive it out, with programmable polarity. Two line-match interrupts and one interrupt on the rising edge of the effective write enable are raised as single-cycle pulses, each with its own enable. Sync polarities act at once. Every other setting is copied into a shadow set only at a vertical sync edge.

Top module: `capture_window_gate`

## Requirements
- R1: A sample is written (`wr_strobe`=1 one cycle after it is presented) in field mode exactly when its pixel index p and line index l satisfy px_start <= p < px_start+px_count and ln_start <= l < ln_start+ln_count. Pixel 0 is the sample present in the cycle the horizontal sync becomes active. Line 0 is the first line that starts after a vertical sync edge.
- R2: A sync polarity bit of 1 makes that sync active-low. A bit of 0 makes it active-high. Only the transition into the active level counts as an edge.
- R3: In write-enable mode with the AND rule (`cfg_comb_or`=0), a sample is written only when it is in the window and `shared_in` is 1 in the same cycle.
- R4: In write-enable mode with the OR rule (`cfg_comb_or`=1), a sample is written when it is in the window or `shared_in` is 1.
- R5: In field mode with `cfg_fid_master`=0, `field_id` takes the value `shared_in` XOR `cfg_fid_pol` at each vertical sync edge, and `fid_oe` stays 0.
- R6: In field mode with `cfg_fid_master`=1, `field_id` toggles at each vertical sync edge. `fid_oe` is 1 and `fid_drive` equals `field_id` XOR `cfg_fid_pol`.
- R7: `cfg_lsb_drop`=n (0..7) forces the lowest n bits of the sample to zero before any further processing.
- R8: With `cfg_reduce`=1, `pix_out` is zero above bit 7. Bits 7:0 are bits [s+7:s] of the sample, where s=`cfg_shift`. They read 0xFF when any sample bit above s+7 is set.
- R9: `irq_line0` (or `irq_line1`) is a one-cycle pulse, one cycle after the horizontal sync edge that starts the line whose index equals `cfg_irq0_line` (or `cfg_irq1_line`).
- R10: `irq_wen` pulses for one cycle in the same cycle that `wr_strobe` goes from 0 to 1.
- R11: `cfg_irq_en` bit 0 enables `irq_line0`, bit 1 enables `irq_line1` and bit 2 enables `irq_wen`. A cleared bit keeps that output at 0.
- R12: All settings except the sync polarities are captured only at a vertical sync edge. A change between edges has no effect on the frame in progress.
- R13: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_in | input | 14 | Raw sensor sample, MSB-aligned |
| hsync_in | input | 1 | Horizontal sync |
| vsync_in | input | 1 | Vertical sync |
| shared_in | input | 1 | Shared pin: external write enable or field identifier |
| cfg_hs_pol | input | 1 | 1 = horizontal sync active-low |
| cfg_vs_pol | input | 1 | 1 = vertical sync active-low |
| cfg_px_start | input | 12 | First pixel of the window |
| cfg_px_count | input | 12 | Pixels per window line |
| cfg_ln_start | input | 12 | First line of the window |
| cfg_ln_count | input | 12 | Lines in the window |
| cfg_pin_wen | input | 1 | 1 = shared pin is write enable, 0 = field identifier |
| cfg_comb_or | input | 1 | 1 = OR rule, 0 = AND rule |
| cfg_fid_pol | input | 1 | Field identifier polarity |
| cfg_fid_master | input | 1 | 1 = block generates the field identifier |
| cfg_lsb_drop | input | 3 | Number of low sample bits cleared |
| cfg_reduce | input | 1 | 1 = 8-bit reduced output |
| cfg_shift | input | 3 | Slice position for reduction |
| cfg_irq0_line | input | 12 | Line index for `irq_line0` |
| cfg_irq1_line | input | 12 | Line index for `irq_line1` |
| cfg_irq_en | input | 3 | Interrupt enables |
| wr_strobe | output | 1 | Memory write strobe for `pix_out` |
| pix_out | output | 14 | Processed sample |
| field_id | output | 1 | Tracked field identifier |
| fid_drive | output | 1 | Field identifier value to drive onto the pin |
| fid_oe | output | 1 | Output enable for the shared pin |
| irq_line0 | output | 1 | First line-match interrupt |
| irq_line1 | output | 1 | Second line-match interrupt |
| irq_wen | output | 1 | Write-enable rising-edge interrupt |

## Verification
A wrong pixel or line count shows up in the first affected line as a strobe that covers the wrong pixels, or as a line interrupt that arrives at the wrong line. In both cases the error is visible one clock after the faulty sample. A shadow setting loaded at the wrong time shows as a changed strobe count inside the frame where the live setting changed. A wrong combine rule or slice shows on the very next written sample. Field-tracking faults show right after the next vertical sync edge.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
    typedef enum logic { PIN_FIELD = 1'b0, PIN_WEN = 1'b1 } pin_mode_e;
    typedef enum logic { COMB_AND = 1'b0, COMB_OR = 1'b1 } comb_e;
    localparam int RED_W = 8;
endpackage

// File: rtl/cwg_pos.sv
module cwg_pos #(
    parameter int PW = 12,
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hs_act,
    input  logic          vs_act,
    output logic          hs_edge,
    output logic          vs_edge,
    output logic [PW-1:0] px_cur,
    output logic [LW-1:0] ln_cur
);
    typedef struct packed {
        logic          hs_prev;
        logic          vs_prev;
        logic [PW-1:0] px;
        logic [LW-1:0] ln;
    } pos_t;

    pos_t q, d;

    always_comb begin
        hs_edge = hs_act & ~q.hs_prev;
        vs_edge = vs_act & ~q.vs_prev;
        // pixel index saturates so a missing sync never wraps into the window
        if (hs_edge)
            px_cur = '0;
        else if (&q.px)
            px_cur = q.px;
        else
            px_cur = q.px + 1'b1;
        // all-ones marks "before line 0"; the next line start wraps it to 0
        if (vs_edge)
            ln_cur = hs_edge ? '0 : '1;
        else if (hs_edge)
            ln_cur = q.ln + 1'b1;
        else
            ln_cur = q.ln;
        d.hs_prev = hs_act;
        d.vs_prev = vs_act;
        d.px      = px_cur;
        d.ln      = ln_cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.hs_prev <= 1'b0;
            q.vs_prev <= 1'b0;
            q.px      <= '1;
            q.ln      <= '1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/cwg_reduce.sv
module cwg_reduce
    import cwg_pkg::*;
#(
    parameter int DW = 14
) (
    input  logic [DW-1:0] data_in,
    input  logic [2:0]    drop,
    input  logic          red_en,
    input  logic [2:0]    shift,
    output logic [DW-1:0] data_out
);
    logic [DW-1:0]    low_mask;
    logic [DW-1:0]    kept;
    logic [DW-1:0]    shifted;
    logic             sat;
    logic [RED_W-1:0] slice;

    always_comb begin
        low_mask = (DW'(1) << drop) - DW'(1);
        kept     = data_in & ~low_mask;
        shifted  = kept >> shift;
        sat      = (shifted >> RED_W) != '0;
        slice    = sat ? {RED_W{1'b1}} : shifted[RED_W-1:0];
        data_out = red_en ? DW'(slice) : kept;
    end
endmodule

// File: rtl/capture_window_gate.sv
module capture_window_gate
    import cwg_pkg::*;
#(
    parameter int DW = 14,
    parameter int PW = 12,
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] pix_in,
    input  logic          hsync_in,
    input  logic          vsync_in,
    input  logic          shared_in,
    input  logic          cfg_hs_pol,
    input  logic          cfg_vs_pol,
    input  logic [PW-1:0] cfg_px_start,
    input  logic [PW-1:0] cfg_px_count,
    input  logic [LW-1:0] cfg_ln_start,
    input  logic [LW-1:0] cfg_ln_count,
    input  logic          cfg_pin_wen,
    input  logic          cfg_comb_or,
    input  logic          cfg_fid_pol,
    input  logic          cfg_fid_master,
    input  logic [2:0]    cfg_lsb_drop,
    input  logic          cfg_reduce,
    input  logic [2:0]    cfg_shift,
    input  logic [LW-1:0] cfg_irq0_line,
    input  logic [LW-1:0] cfg_irq1_line,
    input  logic [2:0]    cfg_irq_en,
    output logic          wr_strobe,
    output logic [DW-1:0] pix_out,
    output logic          field_id,
    output logic          fid_drive,
    output logic          fid_oe,
    output logic          irq_line0,
    output logic          irq_line1,
    output logic          irq_wen
);
    localparam int NIRQ = 3;

    typedef struct packed {
        logic [PW-1:0]   px_start;
        logic [PW-1:0]   px_count;
        logic [LW-1:0]   ln_start;
        logic [LW-1:0]   ln_count;
        pin_mode_e       mode;
        comb_e           comb;
        logic            fid_pol;
        logic            fid_master;
        logic [2:0]      drop;
        logic            red_en;
        logic [2:0]      shift;
        logic [LW-1:0]   irq0_line;
        logic [LW-1:0]   irq1_line;
        logic [NIRQ-1:0] irq_en;
    } shadow_t;

    typedef struct packed {
        shadow_t         sh;
        logic            eff_prev;
        logic            field;
        logic            wr;
        logic [DW-1:0]   pix;
        logic [NIRQ-1:0] irq;
    } state_t;

    state_t s_q, s_d;

    logic          hs_act, vs_act, hs_edge, vs_edge;
    logic [PW-1:0] px_cur;
    logic [LW-1:0] ln_cur;
    logic [DW-1:0] pix_proc;
    logic          in_win, eff_wen;

    assign hs_act = hsync_in ^ cfg_hs_pol;
    assign vs_act = vsync_in ^ cfg_vs_pol;

    cwg_pos #(.PW(PW), .LW(LW)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .hs_act  (hs_act),
        .vs_act  (vs_act),
        .hs_edge (hs_edge),
        .vs_edge (vs_edge),
        .px_cur  (px_cur),
        .ln_cur  (ln_cur)
    );

    cwg_reduce #(.DW(DW)) u_red (
        .data_in  (pix_in),
        .drop     (s_q.sh.drop),
        .red_en   (s_q.sh.red_en),
        .shift    (s_q.sh.shift),
        .data_out (pix_proc)
    );

    always_comb begin
        s_d = s_q;
        in_win = (px_cur >= s_q.sh.px_start)
              && ((px_cur - s_q.sh.px_start) < s_q.sh.px_count)
              && (ln_cur >= s_q.sh.ln_start)
              && ((ln_cur - s_q.sh.ln_start) < s_q.sh.ln_count);
        if (s_q.sh.mode == PIN_WEN)
            eff_wen = (s_q.sh.comb == COMB_OR) ? (in_win | shared_in)
                                               : (in_win & shared_in);
        else
            eff_wen = in_win;

        s_d.wr       = eff_wen;
        s_d.pix      = pix_proc;
        s_d.eff_prev = eff_wen;
        s_d.irq[0]   = hs_edge && (ln_cur == s_q.sh.irq0_line) && s_q.sh.irq_en[0];
        s_d.irq[1]   = hs_edge && (ln_cur == s_q.sh.irq1_line) && s_q.sh.irq_en[1];
        s_d.irq[2]   = eff_wen && !s_q.eff_prev && s_q.sh.irq_en[2];

        if (vs_edge) begin
            s_d.sh.px_start   = cfg_px_start;
            s_d.sh.px_count   = cfg_px_count;
            s_d.sh.ln_start   = cfg_ln_start;
            s_d.sh.ln_count   = cfg_ln_count;
            s_d.sh.mode       = pin_mode_e'(cfg_pin_wen);
            s_d.sh.comb       = comb_e'(cfg_comb_or);
            s_d.sh.fid_pol    = cfg_fid_pol;
            s_d.sh.fid_master = cfg_fid_master;
            s_d.sh.drop       = cfg_lsb_drop;
            s_d.sh.red_en     = cfg_reduce;
            s_d.sh.shift      = cfg_shift;
            s_d.sh.irq0_line  = cfg_irq0_line;
            s_d.sh.irq1_line  = cfg_irq1_line;
            s_d.sh.irq_en     = cfg_irq_en;
            // field tracking follows the settings that take effect at this edge
            if (!cfg_pin_wen)
                s_d.field = cfg_fid_master ? ~s_q.field : (shared_in ^ cfg_fid_pol);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign wr_strobe = s_q.wr;
    assign pix_out   = s_q.pix;
    assign field_id  = s_q.field;
    assign fid_oe    = (s_q.sh.mode == PIN_FIELD) && s_q.sh.fid_master;
    assign fid_drive = s_q.field ^ s_q.sh.fid_pol;
    assign irq_line0 = s_q.irq[0];
    assign irq_line1 = s_q.irq[1];
    assign irq_wen   = s_q.irq[2];

    // R3: under the AND rule a write needs the pin high in the sample cycle
    p_and_needs_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sh.mode == PIN_WEN && s_q.sh.comb == COMB_AND && !shared_in) |=> !wr_strobe);

    // R4: under the OR rule a high pin always writes
    p_or_pin_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sh.mode == PIN_WEN && s_q.sh.comb == COMB_OR && shared_in) |=> wr_strobe);

    // R8: reduced output never carries bits above the slice
    p_reduce_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sh.red_en |=> (pix_out[DW-1:RED_W] == '0));

    // R9: line interrupts are single-cycle pulses
    p_line0_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line0 |=> !irq_line0);
    p_line1_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line1 |=> !irq_line1);

    // R10: the write-enable interrupt marks a rising strobe
    p_wen_irq_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wen |-> (wr_strobe && !$past(wr_strobe)));

    // R6: the pin is driven only while the block generates the field identifier
    p_oe_field_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fid_oe |-> !$past(vs_edge && cfg_pin_wen));
endmodule

// File: tb/tb_capture_window_gate.sv
module tb_capture_window_gate;
    localparam int CLK_P = 10;
    localparam int NVEC  = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [13:0] pix_in;
    logic        hsync_in, vsync_in, shared_in;
    logic        cfg_hs_pol, cfg_vs_pol;
    logic [11:0] cfg_px_start, cfg_px_count, cfg_ln_start, cfg_ln_count;
    logic        cfg_pin_wen, cfg_comb_or, cfg_fid_pol, cfg_fid_master;
    logic [2:0]  cfg_lsb_drop;
    logic        cfg_reduce;
    logic [2:0]  cfg_shift;
    logic [11:0] cfg_irq0_line, cfg_irq1_line;
    logic [2:0]  cfg_irq_en;
    logic        wr_strobe;
    logic [13:0] pix_out;
    logic        field_id, fid_drive, fid_oe, irq_line0, irq_line1, irq_wen;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int n_wr, n_i0, n_i1, n_i2, n_i2_bad, pos_err;
    int i0_line, i0_px, i1_line, i1_px;
    bit pos_chk;

    // {pixel, lsb_drop, reduce, shift, expected pix_out}
    localparam logic [34:0] VEC [NVEC] = '{
        {14'h3ABC, 3'd0, 1'b0, 3'd0, 14'h3ABC},
        {14'h3ABC, 3'd4, 1'b0, 3'd0, 14'h3AB0},
        {14'h3FFF, 3'd6, 1'b0, 3'd0, 14'h3FC0},
        {14'h00A5, 3'd0, 1'b1, 3'd0, 14'h00A5},
        {14'h0100, 3'd0, 1'b1, 3'd0, 14'h00FF},
        {14'h3ABC, 3'd0, 1'b1, 3'd6, 14'h00EA},
        {14'h0ABC, 3'd0, 1'b1, 3'd4, 14'h00AB},
        {14'h1ABC, 3'd0, 1'b1, 3'd4, 14'h00FF},
        {14'h00FF, 3'd3, 1'b1, 3'd0, 14'h00F8},
        {14'h3ABC, 3'd0, 1'b1, 3'd7, 14'h0075}
    };

    capture_window_gate dut (.*);

    always #(CLK_P/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic vs_pulse();
        vsync_in = ~cfg_vs_pol;
        tick();
        vsync_in = cfg_vs_pol;
        tick();
    endtask

    // window used by the position-accurate test: pixels 2..4, lines 1..2
    function automatic bit exp_win(input int l, input int p);
        return (l >= 1 && l <= 2 && p >= 2 && p <= 4);
    endfunction

    task automatic observe(input int l, input int p);
        if (wr_strobe) n_wr++;
        if (pos_chk && (wr_strobe != exp_win(l, p))) pos_err++;
        if (irq_line0) begin n_i0++; i0_line = l; i0_px = p; end
        if (irq_line1) begin n_i1++; i1_line = l; i1_px = p; end
        if (irq_wen) begin
            n_i2++;
            if (!wr_strobe) n_i2_bad++;
        end
    endtask

    task automatic frame(input int nl, input int np, input bit do_vs);
        n_wr = 0; n_i0 = 0; n_i1 = 0; n_i2 = 0; n_i2_bad = 0; pos_err = 0;
        i0_line = -1; i0_px = -1; i1_line = -1; i1_px = -1;
        if (do_vs) vs_pulse();
        for (int l = 0; l < nl; l++) begin
            hsync_in = ~cfg_hs_pol;
            tick();
            observe(l, 0);
            hsync_in = cfg_hs_pol;
            for (int p = 1; p < np; p++) begin
                tick();
                observe(l, p);
            end
        end
        tick();
    endtask

    task automatic set_window();
        cfg_px_start = 12'd2; cfg_px_count = 12'd3;
        cfg_ln_start = 12'd1; cfg_ln_count = 12'd2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        pix_in = '0; hsync_in = 1'b0; vsync_in = 1'b0; shared_in = 1'b0;
        cfg_hs_pol = 1'b0; cfg_vs_pol = 1'b0;
        cfg_px_start = '0; cfg_px_count = '0; cfg_ln_start = '0; cfg_ln_count = '0;
        cfg_pin_wen = 1'b0; cfg_comb_or = 1'b0; cfg_fid_pol = 1'b0; cfg_fid_master = 1'b0;
        cfg_lsb_drop = '0; cfg_reduce = 1'b0; cfg_shift = '0;
        cfg_irq0_line = '0; cfg_irq1_line = '0; cfg_irq_en = '0;
        repeat (3) tick();
        // R13: outputs held at zero during reset
        chk({wr_strobe, pix_out, field_id, fid_drive, fid_oe, irq_line0, irq_line1, irq_wen} == '0,
            "R13 reset outputs", int'(pix_out), 0);
        rst_n = 1'b1;
        tick();

        // R7 / R8 / R1: sample path table, one single-pixel frame per vector
        for (int v = 0; v < NVEC; v++) begin
            cfg_px_start = '0; cfg_px_count = 12'd1; cfg_ln_start = '0; cfg_ln_count = 12'd1;
            cfg_lsb_drop = VEC[v][20:18];
            cfg_reduce   = VEC[v][17];
            cfg_shift    = VEC[v][16:14];
            vs_pulse();
            pix_in   = VEC[v][34:21];
            hsync_in = 1'b1;
            tick();
            chk(pix_out == VEC[v][13:0] && wr_strobe, "R7/R8 sample path",
                int'(pix_out), int'(VEC[v][13:0]));
            hsync_in = 1'b0;
            pix_in   = '0;
            tick();
        end
        cfg_lsb_drop = '0; cfg_reduce = 1'b0; cfg_shift = '0;

        // R1 / R9 / R10: position-accurate window in field mode
        set_window();
        cfg_irq0_line = 12'd2; cfg_irq1_line = 12'd0; cfg_irq_en = 3'b111;
        pos_chk = 1;
        frame(4, 8, 1);
        pos_chk = 0;
        chk(pos_err == 0, "R1 window positions", pos_err, 0);
        chk(n_wr == 6, "R1 window strobe count", n_wr, 6);
        chk(n_i0 == 1 && i0_line == 2 && i0_px == 0, "R9 irq_line0 at line 2", i0_line, 2);
        chk(n_i1 == 1 && i1_line == 0 && i1_px == 0, "R9 irq_line1 at line 0", i1_line, 0);
        chk(n_i2 == 2 && n_i2_bad == 0, "R10 irq_wen on strobe rise", n_i2, 2);

        // R2: active-low syncs give the same window
        cfg_hs_pol = 1'b1; cfg_vs_pol = 1'b1;
        hsync_in = 1'b1; vsync_in = 1'b1;
        tick();
        frame(4, 8, 1);
        chk(n_wr == 6, "R2 active-low syncs", n_wr, 6);
        cfg_hs_pol = 1'b0; cfg_vs_pol = 1'b0;
        hsync_in = 1'b0; vsync_in = 1'b0;
        tick();

        // R11: all interrupts masked
        cfg_irq_en = 3'b000;
        frame(4, 8, 1);
        chk(n_i0 + n_i1 + n_i2 == 0 && n_wr == 6, "R11 masked interrupts", n_i0 + n_i1 + n_i2, 0);
        cfg_irq_en = 3'b100;
        frame(4, 8, 1);
        chk(n_i0 + n_i1 == 0 && n_i2 == 2, "R11 only irq_wen enabled", n_i2, 2);

        // R3: AND rule
        cfg_pin_wen = 1'b1; cfg_comb_or = 1'b0; shared_in = 1'b0;
        frame(4, 8, 1);
        chk(n_wr == 0, "R3 AND with pin low", n_wr, 0);
        shared_in = 1'b1;
        frame(4, 8, 1);
        chk(n_wr == 6, "R3 AND with pin high", n_wr, 6);

        // R4: OR rule
        cfg_comb_or = 1'b1;
        frame(4, 8, 1);
        chk(n_wr == 32, "R4 OR with pin high", n_wr, 32);
        shared_in = 1'b0;
        frame(4, 8, 1);
        chk(n_wr == 6, "R4 OR with pin low", n_wr, 6);
        cfg_pin_wen = 1'b0; cfg_comb_or = 1'b0;

        // R12: live change mid-frame is ignored until the next vertical sync
        frame(1, 2, 1);
        vs_pulse();
        cfg_px_count = 12'd0;
        frame(4, 8, 0);
        chk(n_wr == 6, "R12 mid-frame change ignored", n_wr, 6);
        frame(4, 8, 1);
        chk(n_wr == 0, "R12 change applied next frame", n_wr, 0);
        set_window();

        // R5: field identifier from the sensor
        cfg_fid_master = 1'b0; cfg_fid_pol = 1'b0; shared_in = 1'b1;
        vs_pulse();
        chk(field_id == 1'b1 && fid_oe == 1'b0, "R5 field from pin", int'(field_id), 1);
        shared_in = 1'b0;
        tick();
        chk(field_id == 1'b1, "R5 field held between syncs", int'(field_id), 1);
        cfg_fid_pol = 1'b1; shared_in = 1'b1;
        vs_pulse();
        chk(field_id == 1'b0, "R5 inverted polarity", int'(field_id), 0);
        shared_in = 1'b0;

        // R6: field identifier generated by the block
        cfg_fid_master = 1'b1; cfg_fid_pol = 1'b0;
        vs_pulse();
        chk(field_id == 1'b1 && fid_oe && fid_drive == 1'b1, "R6 toggle to 1", int'(field_id), 1);
        vs_pulse();
        chk(field_id == 1'b0 && fid_oe && fid_drive == 1'b0, "R6 toggle to 0", int'(field_id), 0);
        cfg_fid_pol = 1'b1;
        vs_pulse();
        chk(field_id == 1'b1 && fid_drive == 1'b0, "R6 drive polarity", int'(fid_drive), 0);
        cfg_pin_wen = 1'b1;
        vs_pulse();
        chk(fid_oe == 1'b0 && field_id == 1'b1, "R6 no drive in write-enable mode", int'(fid_oe), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule